// File: doc/BRIEF.md
# Bayer Black Level Correction

This block cleans the dark offset out of raw sensor pixels that arrive one per clock in a 2x2 color mosaic. It tracks where each pixel sits in the mosaic from its row and column parity, then picks one of four channel slots. It subtracts that slot's pedestal. A negative difference is either forced to zero or folded back to its magnitude. The result is multiplied by the slot's gain and saturated to the pixel range. Pixels move on a valid/ready stream with a start-of-frame flag and an end-of-line flag. Both flags come out aligned with their pixel three accepted stages later.

A small write-only register port sets the four pedestals, the four gains, the mosaic phase and a clip control bit. Writes land in shadow registers. A frame only starts using them at its start-of-frame beat, so every pixel of a frame is processed with one consistent setting. The phase value matches the slot numbering to the sensor's framing, flips and rotation.

Top module: `bayer_blc`

## Requirements
- R1: Four separate pedestal registers sit at addresses 0..3 and four separate gain registers at addresses 4..7, each indexed by slot number. After reset every pedestal is 0 and every gain is 0x1000 (1.0).
- R2: For each pixel the slot is 2*(row_parity XOR phase[1]) + (col_parity XOR phase[0]). The phase register is at address 8. The start-of-frame beat has row and column parity 0. Column parity toggles on every accepted beat and returns to 0 after a beat flagged end-of-line. Row parity toggles after each end-of-line beat.
- R3: The slot pedestal is subtracted from the pixel. When the clip bit (address 9, bit 0) is set, a negative difference becomes 0. With the build option REFLECT=0, a negative difference always becomes 0.
- R4: With REFLECT=1 and the clip bit clear, a negative difference is replaced by its magnitude.
- R5: The non-negative difference is multiplied by the gain, which is unsigned with 4 integer and 12 fraction bits. The product is rounded to nearest, with halves rounded up.
- R6: A rounded result above 2^PIX_W-1 leaves as 2^PIX_W-1.
- R7: Register writes take effect from the next accepted start-of-frame beat. A write in the same cycle as that beat waits for the frame after it. A write in the middle of a frame does not change the rest of that frame.
- R8: s_ready equals m_ready. With m_ready held high, a pixel accepted at one clock edge appears on the output after the third edge. With m_ready low, all stages hold and the output stays stable. No beat is dropped or repeated.
- R9: m_sof and m_eol come out on the same beat as the pixel they were accepted with, and never without m_valid.
- R10: Under reset m_valid is 0. After reset, with the default registers, a pixel leaves unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| s_valid | input | 1 | Input pixel valid |
| s_ready | output | 1 | Input pixel ready |
| s_data | input | PIX_W | Input raw pixel |
| s_sof | input | 1 | Input beat is the first of a frame |
| s_eol | input | 1 | Input beat is the last of a line |
| m_valid | output | 1 | Output pixel valid |
| m_ready | input | 1 | Output pixel ready |
| m_data | output | PIX_W | Corrected pixel |
| m_sof | output | 1 | Output beat is the first of a frame |
| m_eol | output | 1 | Output beat is the last of a line |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 4 | Register address |
| cfg_wdata | input | 16 | Register write data |

## Verification
The register port and the frame start can act in the same cycle. A pedestal write can arrive exactly when a start-of-frame beat is accepted. The bench drives the write alongside that beat with the output always ready. It expects the old pedestal on that frame and the new one only on the following frame. A second write lands mid-frame, just before a beat that uses the same slot. That beat must still show the value the frame started with.

// File: rtl/blc_pkg.sv
package blc_pkg;

    localparam int CFG_AW = 4;
    localparam int CFG_DW = 16;

    localparam int ADDR_GAIN_BASE = 4;
    localparam int ADDR_PHASE     = 8;
    localparam int ADDR_CTRL      = 9;

    typedef logic [1:0] slot_t;

    typedef struct packed {
        logic row;
        logic col;
    } parity_t;

    typedef struct packed {
        logic sof;
        logic eol;
    } marks_t;

    // Mosaic slot from pixel parity rotated by the programmed phase.
    function automatic slot_t slot_of(parity_t p, logic [1:0] phase);
        return {p.row ^ phase[1], p.col ^ phase[0]};
    endfunction

endpackage

// File: rtl/blc_cfg_bank.sv
module blc_cfg_bank
    import blc_pkg::*;
#(
    parameter int PIX_W    = 12,
    parameter int GAIN_W   = 16,
    parameter int GAIN_ONE = 4096
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         cfg_we,
    input  logic [CFG_AW-1:0]            cfg_addr,
    input  logic [CFG_DW-1:0]            cfg_wdata,
    input  logic                         load,
    output logic [3:0][PIX_W-1:0]        ped_eff,
    output logic [3:0][GAIN_W-1:0]       gain_eff,
    output logic [1:0]                   phase_eff,
    output logic                         clip_eff
);

    logic [3:0][PIX_W-1:0]  sh_ped,  act_ped;
    logic [3:0][GAIN_W-1:0] sh_gain, act_gain;
    logic [1:0]             sh_phase, act_phase;
    logic                   sh_clip,  act_clip;

    for (genvar k = 0; k < 4; k++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                sh_ped[k]   <= '0;
                act_ped[k]  <= '0;
                sh_gain[k]  <= GAIN_W'(GAIN_ONE);
                act_gain[k] <= GAIN_W'(GAIN_ONE);
            end else begin
                if (cfg_we && cfg_addr == CFG_AW'(k))
                    sh_ped[k] <= cfg_wdata[PIX_W-1:0];
                if (cfg_we && cfg_addr == CFG_AW'(ADDR_GAIN_BASE + k))
                    sh_gain[k] <= cfg_wdata[GAIN_W-1:0];
                if (load) begin
                    act_ped[k]  <= sh_ped[k];
                    act_gain[k] <= sh_gain[k];
                end
            end
        end
        // The frame's first beat already sees the pending shadow values.
        assign ped_eff[k]  = load ? sh_ped[k]  : act_ped[k];
        assign gain_eff[k] = load ? sh_gain[k] : act_gain[k];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_phase  <= '0;
            act_phase <= '0;
            sh_clip   <= 1'b0;
            act_clip  <= 1'b0;
        end else begin
            if (cfg_we && cfg_addr == CFG_AW'(ADDR_PHASE))
                sh_phase <= cfg_wdata[1:0];
            if (cfg_we && cfg_addr == CFG_AW'(ADDR_CTRL))
                sh_clip <= cfg_wdata[0];
            if (load) begin
                act_phase <= sh_phase;
                act_clip  <= sh_clip;
            end
        end
    end

    assign phase_eff = load ? sh_phase : act_phase;
    assign clip_eff  = load ? sh_clip  : act_clip;

endmodule

// File: rtl/blc_parity.sv
module blc_parity
    import blc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       acc,
    input  logic       sof,
    input  logic       eol,
    input  logic [1:0] phase,
    output slot_t      slot
);

    parity_t pos_q;
    parity_t cur;

    always_comb begin
        cur = sof ? parity_t'('0) : pos_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pos_q <= '0;
        end else if (acc) begin
            pos_q.row <= eol ? ~cur.row : cur.row;
            pos_q.col <= eol ? 1'b0     : ~cur.col;
        end
    end

    assign slot = slot_of(cur, phase);

endmodule

// File: rtl/blc_pipe.sv
module blc_pipe
    import blc_pkg::*;
#(
    parameter int PIX_W   = 12,
    parameter int GAIN_W  = 16,
    parameter int FRAC    = 12,
    parameter bit REFLECT = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              adv,
    input  logic              acc,
    input  logic [PIX_W-1:0]  pix,
    input  logic [PIX_W-1:0]  ped,
    input  logic [GAIN_W-1:0] gain,
    input  logic              clip,
    input  logic              sof,
    input  logic              eol,
    output logic              m_valid,
    output logic [PIX_W-1:0]  m_data,
    output logic              m_sof,
    output logic              m_eol
);

    localparam int PROD_W = PIX_W + GAIN_W;
    localparam int SUM_W  = PROD_W + 1;
    localparam logic [SUM_W-1:0] HALF = SUM_W'(1) << (FRAC - 1);
    localparam logic [SUM_W-1:0] MAXV = (SUM_W'(1) << PIX_W) - SUM_W'(1);

    typedef struct packed {
        logic              v;
        marks_t            mk;
        logic [PIX_W-1:0]  mag;
        logic [GAIN_W-1:0] gain;
    } st1_t;

    typedef struct packed {
        logic              v;
        marks_t            mk;
        logic [PROD_W-1:0] prod;
    } st2_t;

    typedef struct packed {
        logic              v;
        marks_t            mk;
        logic [PIX_W-1:0]  data;
    } st3_t;

    st1_t s1;
    st2_t s2;
    st3_t s3;

    // Stage 1 combinational: pedestal removal and negative handling.
    logic [PIX_W:0]   d_pos, d_neg;
    logic             neg, fold;
    logic [PIX_W-1:0] mag;

    assign d_pos = {1'b0, pix} - {1'b0, ped};
    assign d_neg = {1'b0, ped} - {1'b0, pix};
    assign neg   = d_pos[PIX_W];

    if (REFLECT) begin : g_reflect
        assign fold = ~clip;
    end else begin : g_clip_only
        assign fold = 1'b0;
    end

    always_comb begin
        if (!neg)      mag = d_pos[PIX_W-1:0];
        else if (fold) mag = d_neg[PIX_W-1:0];
        else           mag = '0;
    end

    // Stage 3 combinational: round to nearest and saturate.
    logic [SUM_W-1:0] sum, shifted;
    logic [PIX_W-1:0] sat;

    assign sum     = {1'b0, s2.prod} + HALF;
    assign shifted = sum >> FRAC;
    assign sat     = (shifted > MAXV) ? MAXV[PIX_W-1:0] : shifted[PIX_W-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            s1 <= '0;
            s2 <= '0;
            s3 <= '0;
        end else if (adv) begin
            s1.v    <= acc;
            s1.mk   <= acc ? marks_t'({sof, eol}) : marks_t'('0);
            s1.mag  <= mag;
            s1.gain <= gain;

            s2.v    <= s1.v;
            s2.mk   <= s1.mk;
            s2.prod <= PROD_W'(s1.mag) * PROD_W'(s1.gain);

            s3.v    <= s2.v;
            s3.mk   <= s2.mk;
            s3.data <= sat;
        end
    end

    assign m_valid = s3.v;
    assign m_data  = s3.data;
    assign m_sof   = s3.mk.sof;
    assign m_eol   = s3.mk.eol;

endmodule

// File: rtl/bayer_blc.sv
module bayer_blc
    import blc_pkg::*;
#(
    parameter int PIX_W     = 12,
    parameter int GAIN_INT  = 4,
    parameter int GAIN_FRAC = 12,
    parameter bit REFLECT   = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              s_valid,
    output logic              s_ready,
    input  logic [PIX_W-1:0]  s_data,
    input  logic              s_sof,
    input  logic              s_eol,
    output logic              m_valid,
    input  logic              m_ready,
    output logic [PIX_W-1:0]  m_data,
    output logic              m_sof,
    output logic              m_eol,
    input  logic              cfg_we,
    input  logic [3:0]        cfg_addr,
    input  logic [15:0]       cfg_wdata
);

    localparam int GAIN_W   = GAIN_INT + GAIN_FRAC;
    localparam int GAIN_ONE = 1 << GAIN_FRAC;

    logic                   acc, load;
    logic [3:0][PIX_W-1:0]  ped_eff;
    logic [3:0][GAIN_W-1:0] gain_eff;
    logic [1:0]             phase_eff;
    logic                   clip_eff;
    slot_t                  slot;

    assign s_ready = m_ready;
    assign acc     = s_valid & s_ready;
    assign load    = acc & s_sof;

    blc_cfg_bank #(
        .PIX_W    (PIX_W),
        .GAIN_W   (GAIN_W),
        .GAIN_ONE (GAIN_ONE)
    ) u_cfg (
        .clk       (clk),
        .rst       (rst),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .load      (load),
        .ped_eff   (ped_eff),
        .gain_eff  (gain_eff),
        .phase_eff (phase_eff),
        .clip_eff  (clip_eff)
    );

    blc_parity u_par (
        .clk   (clk),
        .rst   (rst),
        .acc   (acc),
        .sof   (s_sof),
        .eol   (s_eol),
        .phase (phase_eff),
        .slot  (slot)
    );

    blc_pipe #(
        .PIX_W   (PIX_W),
        .GAIN_W  (GAIN_W),
        .FRAC    (GAIN_FRAC),
        .REFLECT (REFLECT)
    ) u_pipe (
        .clk     (clk),
        .rst     (rst),
        .adv     (m_ready),
        .acc     (acc),
        .pix     (s_data),
        .ped     (ped_eff[slot]),
        .gain    (gain_eff[slot]),
        .clip    (clip_eff),
        .sof     (s_sof),
        .eol     (s_eol),
        .m_valid (m_valid),
        .m_data  (m_data),
        .m_sof   (m_sof),
        .m_eol   (m_eol)
    );

endmodule

// File: rtl/blc_checker.sv
module blc_checker #(
    parameter int PIX_W = 12
) (
    input logic             clk,
    input logic             rst,
    input logic             s_valid,
    input logic             s_ready,
    input logic             s_sof,
    input logic             m_valid,
    input logic             m_ready,
    input logic [PIX_W-1:0] m_data,
    input logic             m_sof,
    input logic             m_eol
);

    // R8: a stalled output beat keeps its value and flags
    a_r8_hold_when_stalled: assert property (@(posedge clk) disable iff (rst)
        m_valid && !m_ready |=> m_valid && $stable(m_data) && $stable(m_sof) && $stable(m_eol));

    // R8: a beat can only leave after being taken by the sink
    a_r8_no_drop: assert property (@(posedge clk) disable iff (rst)
        $fell(m_valid) |-> $past(m_ready));

    // R9: markers travel only with a valid beat
    a_r9_marks_with_valid: assert property (@(posedge clk) disable iff (rst)
        (m_sof || m_eol) |-> m_valid);

    // R8, R9: frame start shows up after three advancing edges
    a_r9_sof_latency: assert property (@(posedge clk) disable iff (rst)
        (s_valid && s_ready && s_sof) ##1 m_ready ##1 m_ready |=> m_valid && m_sof);

endmodule

bind bayer_blc blc_checker #(.PIX_W(PIX_W)) u_blc_chk (
    .clk     (clk),
    .rst     (rst),
    .s_valid (s_valid),
    .s_ready (s_ready),
    .s_sof   (s_sof),
    .m_valid (m_valid),
    .m_ready (m_ready),
    .m_data  (m_data),
    .m_sof   (m_sof),
    .m_eol   (m_eol)
);

// File: tb/test_bayer_blc.sv
module test_bayer_blc;

    localparam int CLK_PERIOD = 10;
    localparam int NV = 10;
    // pixel, pedestal, gain, clip, expected, requirement number
    localparam int VEC [NV][6] = '{
        '{1000,  100,  4096, 0,  900, 3},  // R3 plain subtraction
        '{ 100,  300,  4096, 1,    0, 3},  // R3 negative clipped
        '{ 100,  300,  4096, 0,  200, 4},  // R4 negative reflected
        '{1000,    0,  8192, 0, 2000, 5},  // R5 gain 2.0
        '{3000,    0,  8192, 0, 4095, 6},  // R6 saturate
        '{   3,    0,  2048, 0,    2, 5},  // R5 1.5 rounds up
        '{   5,    0,  1365, 0,    2, 5},  // R5 ~1.67 rounds to 2
        '{4095,    0, 65535, 0, 4095, 6},  // R6 largest gain
        '{  50,   60, 12288, 0,   30, 4},  // R4 reflected then scaled
        '{4095, 4095,  4096, 1,    0, 3}   // R3 exact zero
    };

    logic        clk = 1'b0;
    logic        rst;
    logic        s_valid, s_sof, s_eol, m_ready, cfg_we;
    logic        s_ready, m_valid, m_sof, m_eol;
    logic [11:0] s_data, m_data;
    logic [3:0]  cfg_addr;
    logic [15:0] cfg_wdata;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    logic [11:0] in_pix [64];
    bit          in_sof [64];
    bit          in_eol [64];
    bit          in_we  [64];
    logic [3:0]  in_addr[64];
    logic [15:0] in_wd  [64];
    logic [11:0] ex_pix [64];
    int          n_in, n_ex;

    always #(CLK_PERIOD/2) clk = ~clk;

    bayer_blc i_bayer_blc (
        .clk(clk), .rst(rst),
        .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data),
        .s_sof(s_sof), .s_eol(s_eol),
        .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data),
        .m_sof(m_sof), .m_eol(m_eol),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata)
    );

    task automatic check(string req, string what, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic clear_q();
        n_in = 0;
        n_ex = 0;
    endtask

    task automatic beat(int pix, bit sof, bit eol, int exp);
        in_pix[n_in] = 12'(pix);
        in_sof[n_in] = sof;
        in_eol[n_in] = eol;
        in_we[n_in]  = 1'b0;
        in_addr[n_in] = '0;
        in_wd[n_in]  = '0;
        ex_pix[n_in] = 12'(exp);
        n_in++;
        n_ex++;
    endtask

    task automatic wr(int addr, int data);
        @(negedge clk);
        cfg_we    = 1'b1;
        cfg_addr  = 4'(addr);
        cfg_wdata = 16'(data);
        @(negedge clk);
        cfg_we    = 1'b0;
    endtask

    // Drive the queued beats and compare every output beat in order.
    task automatic run(string req, bit stall);
        int ii = 0;
        int oo = 0;
        int cyc = 0;
        int extra = 0;
        while ((ii < n_in || oo < n_ex) && cyc < 500) begin
            @(negedge clk);
            m_ready = stall ? (cyc % 3 != 1) : 1'b1;
            if (ii < n_in) begin
                s_valid   = 1'b1;
                s_data    = in_pix[ii];
                s_sof     = in_sof[ii];
                s_eol     = in_eol[ii];
                cfg_we    = in_we[ii];
                cfg_addr  = in_addr[ii];
                cfg_wdata = in_wd[ii];
            end else begin
                s_valid = 1'b0;
                s_sof   = 1'b0;
                s_eol   = 1'b0;
                cfg_we  = 1'b0;
            end
            #1;
            if (m_valid && m_ready) begin
                if (oo < n_ex) begin
                    check(req, $sformatf("beat %0d data", oo), int'(m_data), int'(ex_pix[oo]));
                    check("R9", $sformatf("beat %0d sof", oo), int'(m_sof), int'(in_sof[oo]));
                    check("R9", $sformatf("beat %0d eol", oo), int'(m_eol), int'(in_eol[oo]));
                end else begin
                    check("R8", "duplicate beat", oo, n_ex - 1);
                end
                oo++;
            end
            if (s_valid && s_ready) ii++;
            cyc++;
        end
        @(negedge clk);
        s_valid = 1'b0; s_sof = 1'b0; s_eol = 1'b0; cfg_we = 1'b0; m_ready = 1'b1;
        check("R8", "stream completed", int'(cyc < 500), 1);
        for (int t = 0; t < 4; t++) begin
            @(negedge clk);
            #1;
            if (m_valid) extra++;
        end
        check("R8", "no extra beats", extra, 0);
    endtask

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        total++;
        bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        summary();
    end

    initial begin
        rst = 1'b1; s_valid = 1'b0; s_sof = 1'b0; s_eol = 1'b0; s_data = '0;
        m_ready = 1'b1; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
        repeat (3) @(negedge clk);
        #1;
        check("R10", "valid in reset", int'(m_valid), 0);
        @(negedge clk);
        rst = 1'b0;
        #1;
        check("R8", "ready follows sink", int'(s_ready), 1);
        check("R10", "valid after reset", int'(m_valid), 0);

        // R10: default settings pass pixels unchanged
        clear_q();
        beat(1234, 1, 0, 1234);
        beat(7, 0, 1, 7);
        run("R10", 1'b0);

        // Table of single-pixel frames on slot 0, phase 0
        wr(8, 0);
        for (int v = 0; v < NV; v++) begin
            wr(0, VEC[v][1]);
            wr(4, VEC[v][2]);
            wr(9, VEC[v][3]);
            clear_q();
            beat(VEC[v][0], 1, 1, VEC[v][4]);
            run($sformatf("R%0d vec%0d", VEC[v][5], v), 1'b0);
        end

        // R1: independent gains per slot
        wr(9, 0);
        for (int k = 0; k < 4; k++) wr(k, 0);
        wr(4, 4096); wr(5, 8192); wr(6, 2048); wr(7, 1024);
        clear_q();
        beat(400, 1, 0, 400); beat(400, 0, 1, 800);
        beat(400, 0, 0, 200); beat(400, 0, 1, 100);
        run("R1", 1'b0);

        // R1, R2: independent pedestals, 2x4 frame, phase 0
        wr(0, 10); wr(1, 20); wr(2, 30); wr(3, 40);
        wr(5, 4096); wr(6, 4096); wr(7, 4096);
        clear_q();
        beat(1000, 1, 0, 990); beat(1000, 0, 0, 980);
        beat(1000, 0, 0, 990); beat(1000, 0, 1, 980);
        beat(1000, 0, 0, 970); beat(1000, 0, 0, 960);
        beat(1000, 0, 0, 970); beat(1000, 0, 1, 960);
        run("R2 phase0", 1'b0);

        // R2: phase 3 swaps both row and column
        wr(8, 3);
        clear_q();
        beat(1000, 1, 0, 960); beat(1000, 0, 1, 970);
        beat(1000, 0, 0, 980); beat(1000, 0, 1, 990);
        run("R2 phase3", 1'b0);

        // R2: phase 1 swaps column only; start-of-frame resets parity
        wr(8, 1);
        clear_q();
        beat(1000, 1, 0, 980); beat(1000, 0, 1, 990);
        beat(1000, 0, 0, 960); beat(1000, 0, 1, 970);
        beat(1000, 1, 0, 980); beat(1000, 0, 1, 990);
        run("R2 phase1", 1'b0);

        // R7: write alongside frame start, then a mid-frame write
        wr(8, 0);
        clear_q();
        beat(1000, 1, 1, 990);
        in_we[0] = 1'b1; in_addr[0] = 4'd0; in_wd[0] = 16'd500;
        run("R7 same-cycle write", 1'b0);
        clear_q();
        beat(1000, 1, 0, 500); beat(1000, 0, 0, 980); beat(1000, 0, 1, 500);
        in_we[1] = 1'b1; in_addr[1] = 4'd0; in_wd[1] = 16'd700;
        run("R7 mid-frame write", 1'b0);
        clear_q();
        beat(1000, 1, 1, 300);
        run("R7 next frame", 1'b0);

        // R8: backpressure keeps order and count
        for (int k = 0; k < 4; k++) wr(k, 0);
        clear_q();
        for (int b = 0; b < 8; b++)
            beat(1000 + b * 10, b == 0, (b % 4) == 3, 1000 + b * 10);
        run("R8 backpressure", 1'b1);

        summary();
    end

endmodule